// File: doc/BRIEF.md
# Timer Compare Channel with PWM Output

This block is a single timer channel: a free-running counter whose period comes from a period register, together with one compare register that sets a match point or a duty value. From the relation between the counter and the compare value, the channel drives one reference signal. That signal can toggle on a match, produce PWM with the active phase first, or produce PWM with the active phase last. The counter either counts up and wraps, which gives edge-aligned PWM, or counts up and then down, which gives center-aligned PWM.

The period and compare values are double-buffered. Each has a written (preload) copy and an active (shadow) copy. When buffering is enabled, a written value only reaches the active copy at an update event. An update event is either the counter's natural turnover or a software strobe. The software strobe also restarts the counter, so all active values can be set before counting begins. A polarity bit and an enable bit shape the output pin. A match flag is cleared by writing a one to a clear strobe, and it raises an interrupt when the interrupt is enabled.

Top module: `pwm_timer_chan`

## Requirements
- R1: During and after a synchronous reset, cnt_q is 0, oc_ref is 0, match_flag is 0, irq is 0 and oc_pin is 0. The active period resets to all ones and the active compare value resets to 0.
- R2: When ctr_center is 0 and cnt_run is 1, the counter steps up by one per clock. In the cycle after it holds a value at or above the active period, it holds 0, and that turnover is an update event. When cnt_run is 0, the counter holds its value.
- R3: When ctr_center is 1, the counter counts up to the active period, then down to 0, then up again. The clock on which it leaves 0 while counting down is an update event. With an active period of 0, the counter stays at 0 and every running clock is an update event.
- R4: When prd_buf_en or cmp_buf_en is 1, a write lands only in the preload copy and reaches the active copy at the next update event. When the enable is 0, a write becomes active on the next clock.
- R5: A one-clock pulse on upd_req is an update event. On the next clock, cnt_q is 0, the counter direction is up, and both active registers hold their preload values.
- R6: With out_mode 3'b011 (toggle), oc_ref inverts on the clock after a running cycle in which cnt_q equals the active compare value.
- R7: With out_mode 3'b110 (PWM mode 1), oc_ref in the cycle after cnt_q held v is 1 exactly when v is less than the active compare value. A compare value of 0 therefore gives 0% duty, and a compare value above the period gives 100% duty.
- R8: With out_mode 3'b111 (PWM mode 2), oc_ref is the inverse of the R7 result.
- R9: With any other out_mode code, oc_ref holds its value.
- R10: match_flag becomes 1 on the clock after a running cycle with cnt_q equal to the active compare value, in every mode. A flag_clr pulse clears it, but a match in the same cycle takes priority. irq equals match_flag AND irq_en.
- R11: oc_pin is 0 when pin_en is 0. Otherwise it is oc_ref when pin_pol is 0, and the inverse of oc_ref when pin_pol is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_run | input | 1 | Counter enable |
| ctr_center | input | 1 | 1 selects up/down (center-aligned) counting |
| out_mode | input | 3 | Reference mode code |
| pin_pol | input | 1 | 1 makes the pin active-low |
| pin_en | input | 1 | Drives the reference onto the pin |
| prd_buf_en | input | 1 | Buffer period writes until update |
| cmp_buf_en | input | 1 | Buffer compare writes until update |
| prd_wr | input | 1 | Period write strobe |
| prd_wdata | input | W | Period write value |
| cmp_wr | input | 1 | Compare write strobe |
| cmp_wdata | input | W | Compare write value |
| upd_req | input | 1 | Software update strobe |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Write-one-to-clear strobe for the match flag |
| cnt_q | output | W | Counter value |
| oc_ref | output | 1 | Reference output |
| oc_pin | output | 1 | Pin output after polarity and enable |
| match_flag | output | 1 | Compare match flag |
| irq | output | 1 | Interrupt request |

## Verification
The shadow-register properties assume that a buffered write and an update event may coincide, and that the preload value is then taken before the new write lands. The stimulus creates that overlap on purpose in its random phase. The wrap property assumes the period can shrink below the current count when buffering is off. The random phase does exactly that by writing small periods unbuffered while the counter runs. Strobes are driven as single-clock pulses at the falling edge, so every rule the properties rely on sees one clean value per cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    OM_HOLD   = 3'b000,
    OM_TOGGLE = 3'b011,
    OM_PWM1   = 3'b110,
    OM_PWM2   = 3'b111
  } om_e;
endpackage

// File: rtl/tmr_shadow.sv
module tmr_shadow #(
  parameter int W = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic         buf_en,
  input  logic [W-1:0] wdata,
  input  logic         uev,
  output logic [W-1:0] act
);
  logic [W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= RST_VAL;
      act   <= RST_VAL;
    end else begin
      if (wr) pre_q <= wdata;
      if (wr && !buf_en) act <= wdata;
      else if (uev)      act <= pre_q;
    end
  end

  // R4
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!uev && !(wr && !buf_en)) |=> $stable(act));
  // R5
  load_on_update_chk: assert property (@(posedge clk) disable iff (rst)
    (uev && !(wr && !buf_en)) |=> act == $past(pre_q));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         center,
  input  logic         ug,
  input  logic [W-1:0] prd,
  output logic [W-1:0] cnt,
  output logic         uev
);
  logic down_q;
  logic top_hit;
  logic bot_hit;

  assign top_hit = (cnt >= prd);
  assign bot_hit = (cnt == '0);

  always_comb begin
    uev = ug;
    if (run) begin
      if (!center)     uev = uev | top_hit;
      else if (!down_q) uev = uev | (top_hit && prd == '0);
      else             uev = uev | bot_hit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || ug) begin
      cnt    <= '0;
      down_q <= 1'b0;
    end else if (run) begin
      if (!center) begin
        cnt <= top_hit ? '0 : cnt + 1'b1;
      end else if (!down_q) begin
        if (top_hit) begin
          if (prd == '0) cnt <= '0;
          else begin
            cnt    <= prd - 1'b1;
            down_q <= 1'b1;
          end
        end else cnt <= cnt + 1'b1;
      end else begin
        if (bot_hit) begin
          down_q <= 1'b0;
          cnt    <= (prd == '0) ? '0 : {{(W-1){1'b0}}, 1'b1};
        end else cnt <= cnt - 1'b1;
      end
    end
  end

  // R2
  edge_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !center && cnt >= prd) |=> cnt == '0);
  // R5
  sw_restart_chk: assert property (@(posedge clk) disable iff (rst)
    ug |=> cnt == '0);
endmodule

// File: rtl/tmr_chan_out.sv
module tmr_chan_out
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [2:0]   mode,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp,
  input  logic         flag_clr,
  input  logic         irq_en,
  input  logic         pin_en,
  input  logic         pin_pol,
  output logic         ref_q,
  output logic         flag_q,
  output logic         irq,
  output logic         pin
);
  om_e  om;
  logic hit;
  logic below;

  assign om    = om_e'(mode);
  assign hit   = run && (cnt == cmp);
  assign below = (cnt < cmp);

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      case (om)
        OM_TOGGLE: if (hit) ref_q <= ~ref_q;
        OM_PWM1:   ref_q <= below;
        OM_PWM2:   ref_q <= ~below;
        default:   ref_q <= ref_q;
      endcase
      if (hit)           flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  assign irq = flag_q & irq_en;
  assign pin = pin_en & (ref_q ^ pin_pol);

  // R10
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> flag_q);
  // R6
  toggle_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (om == OM_TOGGLE && hit) |=> ref_q != $past(ref_q));
  // R9
  hold_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'b000) |=> $stable(ref_q));
endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnt_run,
  input  logic         ctr_center,
  input  logic [2:0]   out_mode,
  input  logic         pin_pol,
  input  logic         pin_en,
  input  logic         prd_buf_en,
  input  logic         cmp_buf_en,
  input  logic         prd_wr,
  input  logic [W-1:0] prd_wdata,
  input  logic         cmp_wr,
  input  logic [W-1:0] cmp_wdata,
  input  logic         upd_req,
  input  logic         irq_en,
  input  logic         flag_clr,
  output logic [W-1:0] cnt_q,
  output logic         oc_ref,
  output logic         oc_pin,
  output logic         match_flag,
  output logic         irq
);
  localparam logic [W-1:0] PRD_RST = '1;
  localparam logic [W-1:0] CMP_RST = '0;

  logic [W-1:0] prd_act;
  logic [W-1:0] cmp_act;
  logic         uev;

  tmr_shadow #(.W(W), .RST_VAL(PRD_RST)) u_prd (
    .clk(clk), .rst(rst), .wr(prd_wr), .buf_en(prd_buf_en),
    .wdata(prd_wdata), .uev(uev), .act(prd_act));

  tmr_shadow #(.W(W), .RST_VAL(CMP_RST)) u_cmp (
    .clk(clk), .rst(rst), .wr(cmp_wr), .buf_en(cmp_buf_en),
    .wdata(cmp_wdata), .uev(uev), .act(cmp_act));

  tmr_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .run(cnt_run), .center(ctr_center),
    .ug(upd_req), .prd(prd_act), .cnt(cnt_q), .uev(uev));

  tmr_chan_out #(.W(W)) u_out (
    .clk(clk), .rst(rst), .run(cnt_run), .mode(out_mode),
    .cnt(cnt_q), .cmp(cmp_act), .flag_clr(flag_clr), .irq_en(irq_en),
    .pin_en(pin_en), .pin_pol(pin_pol), .ref_q(oc_ref),
    .flag_q(match_flag), .irq(irq), .pin(oc_pin));
endmodule

// File: tb/test_pwm_timer_chan.sv
module test_pwm_timer_chan;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cnt_run = 0, ctr_center = 0, pin_pol = 0, pin_en = 0;
  logic prd_buf_en = 0, cmp_buf_en = 0, prd_wr = 0, cmp_wr = 0;
  logic upd_req = 0, irq_en = 0, flag_clr = 0;
  logic [2:0] out_mode = 3'b000;
  logic [W-1:0] prd_wdata = '0, cmp_wdata = '0;
  logic [W-1:0] cnt_q;
  logic oc_ref, oc_pin, match_flag, irq;

  int checks = 0;
  int fails = 0;

  // bench model state
  logic [W-1:0] m_cnt, m_prd_pre, m_prd, m_cmp_pre, m_cmp;
  logic m_down, m_ref, m_flag;

  always #5 clk = ~clk;

  pwm_timer_chan #(.W(W)) i_pwm_timer_chan (
    .clk(clk), .rst(rst), .cnt_run(cnt_run), .ctr_center(ctr_center),
    .out_mode(out_mode), .pin_pol(pin_pol), .pin_en(pin_en),
    .prd_buf_en(prd_buf_en), .cmp_buf_en(cmp_buf_en),
    .prd_wr(prd_wr), .prd_wdata(prd_wdata), .cmp_wr(cmp_wr),
    .cmp_wdata(cmp_wdata), .upd_req(upd_req), .irq_en(irq_en),
    .flag_clr(flag_clr), .cnt_q(cnt_q), .oc_ref(oc_ref), .oc_pin(oc_pin),
    .match_flag(match_flag), .irq(irq));

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic exp_pin();
    return pin_en & (m_ref ^ pin_pol);
  endfunction

  task automatic model_reset();
    m_cnt = '0; m_down = 0; m_ref = 0; m_flag = 0;
    m_prd_pre = '1; m_prd = '1; m_cmp_pre = '0; m_cmp = '0;
  endtask

  // next state from requirements R2..R10
  task automatic model_step();
    logic uev, hit;
    logic [W-1:0] ncnt;
    logic ndown;
    uev = upd_req; ncnt = m_cnt; ndown = m_down;
    hit = cnt_run && (m_cnt == m_cmp);
    if (upd_req) begin
      ncnt = '0; ndown = 0;
    end else if (cnt_run) begin
      if (!ctr_center) begin
        if (m_cnt >= m_prd) begin ncnt = '0; uev = 1; end
        else ncnt = m_cnt + 1;
      end else if (!m_down) begin
        if (m_cnt >= m_prd) begin
          if (m_prd == 0) begin ncnt = '0; uev = 1; end
          else begin ncnt = m_prd - 1; ndown = 1; end
        end else ncnt = m_cnt + 1;
      end else begin
        if (m_cnt == 0) begin
          uev = 1; ndown = 0;
          ncnt = (m_prd == 0) ? '0 : 1;
        end else ncnt = m_cnt - 1;
      end
    end
    case (out_mode)
      3'b011: if (hit) m_ref = ~m_ref;
      3'b110: m_ref = (m_cnt < m_cmp);
      3'b111: m_ref = !(m_cnt < m_cmp);
      default: ;
    endcase
    if (hit) m_flag = 1;
    else if (flag_clr) m_flag = 0;
    if (prd_wr && !prd_buf_en) m_prd = prd_wdata;
    else if (uev) m_prd = m_prd_pre;
    if (cmp_wr && !cmp_buf_en) m_cmp = cmp_wdata;
    else if (uev) m_cmp = m_cmp_pre;
    if (prd_wr) m_prd_pre = prd_wdata;
    if (cmp_wr) m_cmp_pre = cmp_wdata;
    m_cnt = ncnt; m_down = ndown;
  endtask

  task automatic compare(input string tag);
    chk(cnt_q == m_cnt, tag, "cnt_q", int'(cnt_q), int'(m_cnt));
    chk(oc_ref == m_ref, tag, "oc_ref", int'(oc_ref), int'(m_ref));
    chk(match_flag == m_flag, tag, "match_flag", int'(match_flag), int'(m_flag));
    chk(irq == (m_flag & irq_en), tag, "irq", int'(irq), int'(m_flag & irq_en));
    chk(oc_pin == exp_pin(), tag, "oc_pin", int'(oc_pin), int'(exp_pin()));
  endtask

  // inputs are set at a falling edge before calling
  task automatic tick(input string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    prd_wr = 0; cmp_wr = 0; upd_req = 0; flag_clr = 0;
    compare(tag);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  task automatic setup(input logic [W-1:0] prd, input logic [W-1:0] cmp,
                       input string tag);
    prd_buf_en = 1; cmp_buf_en = 1;
    prd_wr = 1; prd_wdata = prd; cmp_wr = 1; cmp_wdata = cmp;
    tick(tag);
    upd_req = 1;
    tick(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int highs;
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    compare("R1 during reset");
    rst = 0;
    tick("R1 after reset");

    // R5: update strobe restarts and loads shadows
    cnt_run = 1; out_mode = 3'b110;
    run(5, "R2 count from reset");
    setup(8'd9, 8'd4, "R5 update load");
    chk(cnt_q == 0, "R5", "cnt after strobe", int'(cnt_q), 0);

    // R7 duty counts
    run(10, "R7 settle");
    highs = 0;
    for (int i = 0; i < 10; i++) begin tick("R7 pwm1"); highs += int'(oc_ref); end
    chk(highs == 4, "R7", "high cycles per period", highs, 4);
    setup(8'd9, 8'd0, "R7 zero duty");
    run(12, "R7 zero duty");
    chk(oc_ref == 0, "R7", "ref at 0% duty", int'(oc_ref), 0);
    setup(8'd9, 8'd12, "R7 full duty");
    run(12, "R7 full duty");
    chk(oc_ref == 1, "R7", "ref at 100% duty", int'(oc_ref), 1);

    // R8 inverse mode
    out_mode = 3'b111;
    setup(8'd7, 8'd3, "R8 pwm2");
    run(20, "R8 pwm2");

    // R3 center counting, including period 0
    ctr_center = 1; out_mode = 3'b110;
    setup(8'd6, 8'd2, "R3 center");
    run(30, "R3 center");
    setup(8'd0, 8'd0, "R3 zero period");
    run(5, "R3 zero period");
    ctr_center = 0;

    // R4 buffered write waits for update, unbuffered lands next clock
    setup(8'd9, 8'd5, "R4 base");
    run(3, "R4 base");
    prd_wr = 1; prd_wdata = 8'd3; tick("R4 buffered prd");
    run(12, "R4 buffered prd");
    cmp_buf_en = 0; cmp_wr = 1; cmp_wdata = 8'd1; tick("R4 direct cmp");
    run(6, "R4 direct cmp");

    // R6 toggle and R10 flag/irq
    out_mode = 3'b011; irq_en = 1;
    setup(8'd5, 8'd2, "R6 toggle");
    run(14, "R6 toggle");
    flag_clr = 1; tick("R10 clear");
    run(3, "R10 after clear");

    // R9 hold mode, R11 pin shaping
    out_mode = 3'b101;
    run(8, "R9 hold");
    pin_en = 1; run(4, "R11 pin high");
    pin_pol = 1; run(4, "R11 pin low");
    pin_en = 0; run(2, "R11 pin off");

    // mixed random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 15) == 0) begin
        case ($urandom_range(0, 4))
          0: out_mode = 3'b000;
          1: out_mode = 3'b011;
          2: out_mode = 3'b110;
          3: out_mode = 3'b111;
          default: out_mode = 3'b101;
        endcase
        ctr_center = 1'($urandom_range(0, 1));
        prd_buf_en = 1'($urandom_range(0, 1));
        cmp_buf_en = 1'($urandom_range(0, 1));
        pin_pol = 1'($urandom_range(0, 1));
        pin_en = 1'($urandom_range(0, 1));
        irq_en = 1'($urandom_range(0, 1));
      end
      cnt_run = ($urandom_range(0, 9) != 0);
      prd_wr = ($urandom_range(0, 19) == 0);
      prd_wdata = W'($urandom_range(0, 20));
      cmp_wr = ($urandom_range(0, 9) == 0);
      cmp_wdata = W'($urandom_range(0, 22));
      upd_req = ($urandom_range(0, 39) == 0);
      flag_clr = ($urandom_range(0, 3) == 0);
      tick("mixed random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule